// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words with a write port and a read port on separate clocks. Besides the usual full and empty indications, it raises an almost-empty flag and an almost-full flag. The points at which these two flags switch are set by two threshold values. Each threshold is held as a low byte plus a high part that carries the remaining bits. The write and read pointers cross between the clock domains as Gray code through two-stage synchronizers.

A single programming pin, `prog_n`, steers both data ports. With `prog_n` high, the ports move words into and out of the buffer. With `prog_n` low, the write port stores `din` into the threshold registers, one register per enabled write. The read port returns the threshold registers on `dout`, one per enabled read. Each side keeps its own selector, and the selector steps through a fixed four-register cycle. A burst may stop at any register. The next programming access then continues from that register.

Top module: `fifo9_prog_flags`

## Requirements
- R1: After reset `empty` and `almost_empty` are 1, `full`, `almost_full` and `dout` are 0, both thresholds equal 7, and both selectors point at the empty-threshold low byte.
- R2: On a `wclk` rise with `prog_n` high, `we_n` low and `full` low, `din` enters the buffer. A write attempted while `full` is high is dropped and leaves the contents unchanged.
- R3: On an `rclk` rise with `prog_n` high, both `re1_n` and `re2_n` low and `empty` low, `dout` takes the oldest stored word. A read while `empty` is high leaves `dout` and the contents unchanged, and `dout` holds whenever no read is enabled.
- R4: `empty` is 1 exactly when the stored count is 0, and `full` is 1 exactly when the count equals 2^AW (256 by default). Each flag reflects an access made on the other side within three cycles.
- R5: `almost_empty` is 1 when the stored count is less than or equal to the empty threshold.
- R6: `almost_full` is 1 when the free space (2^AW minus the count) is less than or equal to the full threshold.
- R7: On a `wclk` rise with `prog_n` low and `we_n` low, `din` is written into the register picked by the write selector, and the selector then advances. The selector order is: selector 0 is the empty-threshold low byte (`din[7:0]`), 1 is the empty-threshold high part (`din[AW-8:0]`), 2 is the full-threshold low byte, and 3 is the full-threshold high part. After 3 it wraps to 0.
- R8: On an `rclk` rise with `prog_n` low and both read enables low, `dout` shows the register picked by the read selector, zero-extended to 9 bits. The read selector then advances in the same four-step order. Bits above the stored width of a high part read as 0.
- R9: With `we_n` high nothing is written, neither to the buffer nor to the threshold registers, whatever the level of `prog_n`.
- R10: Returning `prog_n` high keeps each selector where it stopped. A later programming access continues from that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wclk | input | 1 | Write clock |
| we_n | input | 1 | Active-low write enable |
| prog_n | input | 1 | Low selects the threshold registers, high selects the buffer |
| din | input | DW | Write data |
| full | output | 1 | Buffer holds 2^AW words (write domain) |
| almost_full | output | 1 | Free space at or below the full threshold (write domain) |
| rclk | input | 1 | Read clock |
| re1_n | input | 1 | Active-low read enable, first of two |
| re2_n | input | 1 | Active-low read enable, second of two |
| dout | output | DW | Read data or threshold readback |
| empty | output | 1 | Buffer holds no words (read domain) |
| almost_empty | output | 1 | Count at or below the empty threshold (read domain) |

## Verification
A wrong pointer or a wrong synchronizer stage shows up as a flag that disagrees with the arithmetic count a few cycles after an access. It can also show up as a word out of order on the first read past the fault. A selector that skips or fails to advance makes the very next readback return a value from the wrong position of the four-register cycle. A threshold that was truncated or mis-stored moves the almost-empty or almost-full edge by at least one word during a full fill and drain sweep.

// File: rtl/fifo9_prog_flags.sv
module fifo9_prog_flags #(
  parameter int AW = 8,
  parameter int DW = 9
) (
  input  logic          rst_n,
  input  logic          wclk,
  input  logic          we_n,
  input  logic          prog_n,
  input  logic [DW-1:0] din,
  output logic          full,
  output logic          almost_full,
  input  logic          rclk,
  input  logic          re1_n,
  input  logic          re2_n,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          almost_empty
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;
  localparam int MW = PW - 8;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rg_s1, rg_s2, wg_s1, wg_s2;
  logic [7:0]    ae_lo, af_lo;
  logic [MW-1:0] ae_hi, af_hi;
  logic [1:0]    wsel, rsel;
  logic [DW-1:0] ofs_view;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b = g;
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  wire rd_en  = !re1_n && !re2_n;
  wire wr_go  = !we_n && prog_n && !full;
  wire ofs_wr = !we_n && !prog_n;
  wire rd_go  = rd_en && prog_n && !empty;
  wire ofs_rd = rd_en && !prog_n;

  wire [PW-1:0] wnext = wbin + 1'b1;
  wire [PW-1:0] rnext = rbin + 1'b1;
  wire [PW-1:0] ae_ofs = {ae_hi, ae_lo};
  wire [PW-1:0] af_ofs = {af_hi, af_lo};
  wire [PW-1:0] wcnt = wbin - g2b(rg_s2);
  wire [PW-1:0] rcnt = g2b(wg_s2) - rbin;

  assign full         = (wcnt == DEPTH_P);
  assign almost_full  = (DEPTH_P - wcnt) <= af_ofs;
  assign empty        = (rcnt == '0);
  assign almost_empty = rcnt <= ae_ofs;

  always_ff @(posedge wclk) begin
    if (wr_go) mem[wbin[AW-1:0]] <= din;
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_go) begin
        wbin  <= wnext;
        wgray <= wnext ^ (wnext >> 1);
      end
    end
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      ae_lo <= 8'd7;
      ae_hi <= '0;
      af_lo <= 8'd7;
      af_hi <= '0;
      wsel  <= 2'd0;
    end else if (ofs_wr) begin
      case (wsel)
        2'd0: ae_lo <= din[7:0];
        2'd1: ae_hi <= din[MW-1:0];
        2'd2: af_lo <= din[7:0];
        default: af_hi <= din[MW-1:0];
      endcase
      wsel <= wsel + 2'd1;
    end
  end

  always_comb begin
    case (rsel)
      2'd0: ofs_view = DW'(ae_lo);
      2'd1: ofs_view = DW'(ae_hi);
      2'd2: ofs_view = DW'(af_lo);
      default: ofs_view = DW'(af_hi);
    endcase
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
      rsel  <= 2'd0;
      dout  <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (rd_go) begin
        dout  <= mem[rbin[AW-1:0]];
        rbin  <= rnext;
        rgray <= rnext ^ (rnext >> 1);
      end else if (ofs_rd) begin
        dout <= ofs_view;
        rsel <= rsel + 2'd1;
      end
    end
  end
endmodule

module fifo9_prog_flags_chk #(
  parameter int AW = 8,
  parameter int DW = 9
) (
  input logic          rst_n,
  input logic          wclk,
  input logic          rclk,
  input logic          we_n,
  input logic          prog_n,
  input logic          re1_n,
  input logic          re2_n,
  input logic          full,
  input logic          almost_full,
  input logic          empty,
  input logic          almost_empty,
  input logic [DW-1:0] dout,
  input logic [AW:0]   wbin,
  input logic [AW:0]   rbin,
  input logic [1:0]    wsel,
  input logic [1:0]    rsel
);
  // R2
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (full && !we_n && prog_n) |=> $stable(wbin));
  // R3
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (empty && !re1_n && !re2_n && prog_n) |=> $stable(rbin));
  // R3
  dout_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (re1_n || re2_n) |=> $stable(dout));
  // R5
  ae_on_empty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |-> almost_empty);
  // R6
  af_on_full_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> almost_full);
  // R7
  wsel_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (!we_n && !prog_n) |=> wsel == $past(wsel) + 2'd1);
  // R8
  rsel_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!re1_n && !re2_n && !prog_n) |=> rsel == $past(rsel) + 2'd1);
  // R9
  idle_write_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    we_n |=> ($stable(wbin) && $stable(wsel)));
endmodule

bind fifo9_prog_flags fifo9_prog_flags_chk #(.AW(AW), .DW(DW)) u_chk (
  .rst_n(rst_n), .wclk(wclk), .rclk(rclk), .we_n(we_n), .prog_n(prog_n),
  .re1_n(re1_n), .re2_n(re2_n), .full(full), .almost_full(almost_full),
  .empty(empty), .almost_empty(almost_empty), .dout(dout),
  .wbin(wbin), .rbin(rbin), .wsel(wsel), .rsel(rsel)
);

// File: tb/tb_fifo9_prog_flags.sv
module tb_fifo9_prog_flags;
  localparam int AW = 8;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we_n = 1'b1, prog_n = 1'b1, re1_n = 1'b1, re2_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic full, almost_full, empty, almost_empty;

  int n_chk = 0;
  int n_fail = 0;
  int ae_thr = 7;
  int af_thr = 7;
  logic [DW-1:0] q[$];
  logic [DW-1:0] last;

  always #2 clk = ~clk;

  fifo9_prog_flags #(.AW(AW), .DW(DW)) dut (
    .rst_n(rst_n), .wclk(clk), .we_n(we_n), .prog_n(prog_n), .din(din),
    .full(full), .almost_full(almost_full), .rclk(clk), .re1_n(re1_n),
    .re2_n(re2_n), .dout(dout), .empty(empty), .almost_empty(almost_empty)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic p_n, input logic [DW-1:0] d);
    prog_n = p_n; we_n = 1'b0; din = d;
    @(negedge clk);
    we_n = 1'b1; prog_n = 1'b1;
  endtask

  task automatic rd(input logic p_n);
    prog_n = p_n; re1_n = 1'b0; re2_n = 1'b0;
    @(negedge clk);
    re1_n = 1'b1; re2_n = 1'b1; prog_n = 1'b1;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic flags(input string req, input int c);
    chk({req, " R4 empty"}, int'(empty), int'(c == 0));
    chk({req, " R4 full"}, int'(full), int'(c == DEPTH));
    chk({req, " R5 almost_empty"}, int'(almost_empty), int'(c <= ae_thr));
    chk({req, " R6 almost_full"}, int'(almost_full), int'((DEPTH - c) <= af_thr));
  endtask

  initial begin
    #200000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dout", int'(dout), 0);
    flags("R1", 0);

    // R9: idle write with prog_n high leaves the buffer empty
    din = 9'h1FF;
    repeat (2) @(negedge clk);
    settle();
    chk("R9 empty", int'(empty), 1);

    // R1/R8: default thresholds read back in selector order
    rd(1'b0); chk("R8 ae_lo default", int'(dout), 7);
    rd(1'b0); chk("R8 ae_hi default", int'(dout), 0);
    rd(1'b0); chk("R8 af_lo default", int'(dout), 7);
    rd(1'b0); chk("R8 af_hi default", int'(dout), 0);

    // R7: program all four, high parts keep only din[0]
    wr(1'b0, 9'h023);
    wr(1'b0, 9'h1FE);
    wr(1'b0, 9'h014);
    wr(1'b0, 9'h002);
    rd(1'b0); chk("R7 ae_lo", int'(dout), 'h23);
    rd(1'b0); chk("R8 ae_hi upper zero", int'(dout), 0);
    rd(1'b0); chk("R7 af_lo", int'(dout), 'h14);
    rd(1'b0); chk("R8 af_hi upper zero", int'(dout), 0);

    // R9: programming mode with we_n high writes nothing
    prog_n = 1'b0; din = 9'h1AA;
    repeat (2) @(negedge clk);
    prog_n = 1'b1;
    rd(1'b0); chk("R9 ae_lo unchanged", int'(dout), 'h23);

    // R10: partial burst of one register
    wr(1'b0, 9'h030);
    ae_thr = 'h30;
    af_thr = 'h14;
    settle();
    flags("R10", 0);

    // R2/R4/R5/R6: fill sweep
    for (int c = 1; c <= DEPTH; c++) begin
      logic [DW-1:0] v;
      v = DW'((c * 37 + 5) & 'h1FF);
      wr(1'b1, v);
      q.push_back(v);
      settle();
      flags("R2 fill", c);
    end
    wr(1'b1, 9'h155);
    settle();
    flags("R2 overflow", DEPTH);

    // R3: drain sweep
    for (int c = DEPTH - 1; c >= 0; c--) begin
      logic [DW-1:0] e;
      e = q.pop_front();
      rd(1'b1);
      chk("R3 data", int'(dout), int'(e));
      last = dout;
      settle();
      flags("R3 drain", c);
    end
    rd(1'b1);
    chk("R3 underflow dout", int'(dout), int'(last));
    settle();
    flags("R3 underflow", 0);

    // R10: selectors resume where they stopped
    wr(1'b0, 9'h0FF);
    rd(1'b0); chk("R10 ae_hi resumed", int'(dout), 1);
    rd(1'b0); chk("R10 af_lo next", int'(dout), 'h14);
    ae_thr = 'h130;
    wr(1'b1, 9'h001);
    settle();
    flags("R5 wide threshold", 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule